// File: doc/BRIEF.md
# Local-Variance Tile Classifier

The block takes one image tile, pixel by pixel in raster order, and works out what kind of content the tile holds. Each pixel is scored by the spread of values in the 3×3 neighbourhood around it. That score gives the pixel one of three labels: flat (uniform), textured, or edge. The block keeps a running total of the textured and edge pixels. When the last pixel of the tile has been taken in, it reports one tile type.

A later edge-detection stage reads the tile type to set its thresholds. Tiles with no edge pixels and only a little texture are reported as one merged smooth class. For these tiles the block raises a skip flag, so the next stage can leave the tile out entirely. Every threshold is an input and stays programmable. The spread score uses no divider: it compares 9·Σx² − (Σx)² against thresholds that are already scaled to match.

Top module: `tile_classifier`

## Requirements
- R1: For a pixel whose 3×3 window lies inside the tile, the score is V = 9·Σx² − (Σx)², taken over the nine pixels centred on it. Pixels arrive in raster order, TILE_W per row and TILE_H rows per tile.
- R2: The pixel label is uniform if V < thr_texture. It is texture if thr_texture ≤ V < thr_edge. It is edge if V ≥ thr_edge.
- R3: Every pixel in the first or last row or column of the tile is labelled uniform. No window uses pixels from another tile.
- R4: The tile type is chosen in this priority order. Code 4 (strong edge) if the edge count ≥ min_strong_cnt. Code 3 (medium edge) if the edge count ≥ min_medium_cnt. Code 2 (edge/texture) if the edge count is nonzero. Code 1 (texture) if the texture count ≥ min_texture_cnt. Code 0 (smooth) otherwise; this covers both uniform tiles and uniform/texture tiles.
- R5: blk_skip is 1 exactly when the reported type is code 0. It is updated together with blk_type.
- R6: blk_valid is a single-cycle pulse. It rises on the clock edge after the edge that accepts the tile's last pixel. blk_type and blk_skip then hold until the next tile is reported.
- R7: A cycle with pix_valid low changes nothing. Idle gaps between pixels leave the result unchanged.
- R8: The label counts start again from zero for every tile. Tiles sent back to back are classified independently of each other.
- R9: While reset is asserted, blk_valid, blk_type and blk_skip are 0. After reset, the next accepted pixel is row 0, column 0 of a new tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_valid | input | 1 | The pixel on pix_data is taken in this cycle |
| pix_data | input | PIX_W | Pixel value |
| thr_texture | input | VAR_W | Lowest score labelled texture |
| thr_edge | input | VAR_W | Lowest score labelled edge |
| min_texture_cnt | input | CNT_W | Texture pixels needed for a texture tile |
| min_medium_cnt | input | CNT_W | Edge pixels needed for a medium-edge tile |
| min_strong_cnt | input | CNT_W | Edge pixels needed for a strong-edge tile |
| blk_valid | output | 1 | One-cycle pulse when a tile result is ready |
| blk_type | output | 3 | Tile type code (0 smooth, 1 texture, 2 edge/texture, 3 medium, 4 strong) |
| blk_skip | output | 1 | Tile is smooth; edge detection can be skipped |

## Verification
The bench sets pixel scores exactly equal to each label threshold, and edge counts exactly equal to each count threshold. A design that swapped < for ≤ would move those tiles into the next class. A spike in a corner pixel lands in only one interior window. A design that scored border pixels or let windows wrap across rows would get a count other than one. Further runs use idle gaps between pixels, tiles sent with no gap between them, and a reset in the middle of a tile. These would expose, in turn, counters that advance on idle cycles, totals carried from one tile into the next, and a pixel position that survives reset.

// File: rtl/tile_cls_pkg.sv
package tile_cls_pkg;

  typedef enum logic [2:0] {
    TT_SMOOTH   = 3'd0,
    TT_TEXTURE  = 3'd1,
    TT_EDGE_TEX = 3'd2,
    TT_MEDIUM   = 3'd3,
    TT_STRONG   = 3'd4
  } tile_type_e;

  typedef enum logic [1:0] {
    PL_UNIFORM = 2'd0,
    PL_TEXTURE = 2'd1,
    PL_EDGE    = 2'd2
  } pix_label_e;

endpackage

// File: rtl/tcl_window.sv
module tcl_window #(
  parameter int PIX_W  = 8,
  parameter int TILE_W = 8,
  parameter int TILE_H = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PIX_W-1:0]   in_pix,
  output logic [9*PIX_W-1:0] win_flat,
  output logic               win_ok,
  output logic               tile_last
);
  localparam int CW = (TILE_W > 2) ? $clog2(TILE_W) : 2;
  localparam int RW = (TILE_H > 2) ? $clog2(TILE_H) : 2;

  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          win_ok_q, last_q;
  logic          at_row_end, at_tile_end, interior_ok;

  logic [PIX_W-1:0] lb_near [TILE_W];
  logic [PIX_W-1:0] lb_far  [TILE_W];
  logic [PIX_W-1:0] win_q   [3][3];

  // position next state
  always_comb begin
    at_row_end  = (col_q == CW'(TILE_W - 1));
    at_tile_end = at_row_end && (row_q == RW'(TILE_H - 1));
    interior_ok = (row_q >= RW'(2)) && (col_q >= CW'(2));
    col_d = col_q;
    row_d = row_q;
    if (in_valid) begin
      col_d = at_row_end ? '0 : col_q + CW'(1);
      if (at_row_end) row_d = at_tile_end ? '0 : row_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      win_ok_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      win_ok_q <= in_valid && interior_ok;
      last_q   <= in_valid && at_tile_end;
    end
  end

  // line buffers and window: data only, no reset
  always_ff @(posedge clk) begin
    if (in_valid) begin
      lb_far[col_q]  <= lb_near[col_q];
      lb_near[col_q] <= in_pix;
      for (int r = 0; r < 3; r++) begin
        win_q[r][0] <= win_q[r][1];
        win_q[r][1] <= win_q[r][2];
      end
      win_q[0][2] <= lb_far[col_q];
      win_q[1][2] <= lb_near[col_q];
      win_q[2][2] <= in_pix;
    end
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign win_flat[(r*3+c)*PIX_W +: PIX_W] = win_q[r][c];
    end
  end

  assign win_ok    = win_ok_q;
  assign tile_last = last_q;

  AST_IDLE_NO_LABEL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !win_ok_q) else $error("idle cycle produced a label"); // R7

endmodule

// File: rtl/tcl_varlabel.sv
module tcl_varlabel
  import tile_cls_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int VAR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic [9*PIX_W-1:0] win_flat,
  input  logic [VAR_W-1:0]   thr_tex,
  input  logic [VAR_W-1:0]   thr_edge,
  output pix_label_e         label
);
  localparam int SUM_W = PIX_W + 4;
  localparam int SQ_W  = 2*PIX_W + 4;

  logic [SUM_W-1:0] sum;
  logic [SQ_W-1:0]  sumsq;
  logic [VAR_W-1:0] lhs, rhs, score;

  always_comb begin
    sum   = '0;
    sumsq = '0;
    for (int i = 0; i < 9; i++) begin
      sum   = sum + SUM_W'(win_flat[i*PIX_W +: PIX_W]);
      sumsq = sumsq + SQ_W'(win_flat[i*PIX_W +: PIX_W]) * SQ_W'(win_flat[i*PIX_W +: PIX_W]);
    end
    lhs   = (VAR_W'(sumsq) << 3) + VAR_W'(sumsq);
    rhs   = VAR_W'(sum) * VAR_W'(sum);
    score = lhs - rhs;
    if (score >= thr_edge)     label = PL_EDGE;
    else if (score >= thr_tex) label = PL_TEXTURE;
    else                       label = PL_UNIFORM;
  end

  AST_SCORE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (lhs >= rhs)) else $error("negative spread score"); // R1

endmodule

// File: rtl/tcl_decide.sv
module tcl_decide
  import tile_cls_pkg::*;
#(
  parameter int TILE_W = 8,
  parameter int TILE_H = 8,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lbl_valid,
  input  pix_label_e       label,
  input  logic             tile_done,
  input  logic [CNT_W-1:0] tex_min,
  input  logic [CNT_W-1:0] med_min,
  input  logic [CNT_W-1:0] strong_min,
  output logic             blk_valid,
  output tile_type_e       blk_type,
  output logic             blk_skip
);
  localparam int INTERIOR = (TILE_W - 2) * (TILE_H - 2);

  logic [CNT_W-1:0] tex_q, edge_q, tex_n, edge_n, tex_d, edge_d;
  tile_type_e       type_d, type_q;
  logic             skip_d, skip_q, valid_q;

  always_comb begin
    tex_n  = tex_q  + CNT_W'(lbl_valid && (label == PL_TEXTURE));
    edge_n = edge_q + CNT_W'(lbl_valid && (label == PL_EDGE));
    tex_d  = tile_done ? '0 : tex_n;
    edge_d = tile_done ? '0 : edge_n;
    if (edge_n >= strong_min)   type_d = TT_STRONG;
    else if (edge_n >= med_min) type_d = TT_MEDIUM;
    else if (edge_n != '0)      type_d = TT_EDGE_TEX;
    else if (tex_n >= tex_min)  type_d = TT_TEXTURE;
    else                        type_d = TT_SMOOTH;
    skip_d = (edge_n == '0) && (tex_n < tex_min);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tex_q   <= '0;
      edge_q  <= '0;
      valid_q <= 1'b0;
      type_q  <= TT_SMOOTH;
      skip_q  <= 1'b0;
    end else begin
      tex_q   <= tex_d;
      edge_q  <= edge_d;
      valid_q <= tile_done;
      if (tile_done) begin
        type_q <= type_d;
        skip_q <= skip_d;
      end
    end
  end

  assign blk_valid = valid_q;
  assign blk_type  = type_q;
  assign blk_skip  = skip_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tex_q) + 32'(edge_q)) <= 32'(INTERIOR)) else $error("label count exceeds interior"); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q) else $error("result pulse too long"); // R6
  AST_SKIP_SMOOTH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (skip_q == (type_q == TT_SMOOTH))) else $error("skip disagrees with type"); // R5

endmodule

// File: rtl/tile_classifier.sv
module tile_classifier
  import tile_cls_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int TILE_W = 8,
  parameter int TILE_H = 8,
  localparam int VAR_W = 2*PIX_W + 8,
  localparam int CNT_W = $clog2(TILE_W*TILE_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [VAR_W-1:0] thr_texture,
  input  logic [VAR_W-1:0] thr_edge,
  input  logic [CNT_W-1:0] min_texture_cnt,
  input  logic [CNT_W-1:0] min_medium_cnt,
  input  logic [CNT_W-1:0] min_strong_cnt,
  output logic             blk_valid,
  output logic [2:0]       blk_type,
  output logic             blk_skip
);
  logic               rst_meta, rst_sync;
  logic [9*PIX_W-1:0] win_flat;
  logic               win_ok, tile_last;
  pix_label_e         label;
  tile_type_e         type_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tcl_window #(.PIX_W(PIX_W), .TILE_W(TILE_W), .TILE_H(TILE_H)) u_win (
    .clk(clk), .rst_n(rst_sync), .in_valid(pix_valid), .in_pix(pix_data),
    .win_flat(win_flat), .win_ok(win_ok), .tile_last(tile_last));

  tcl_varlabel #(.PIX_W(PIX_W), .VAR_W(VAR_W)) u_lbl (
    .clk(clk), .rst_n(rst_sync), .chk_en(win_ok), .win_flat(win_flat),
    .thr_tex(thr_texture), .thr_edge(thr_edge), .label(label));

  tcl_decide #(.TILE_W(TILE_W), .TILE_H(TILE_H), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_sync), .lbl_valid(win_ok), .label(label),
    .tile_done(tile_last), .tex_min(min_texture_cnt), .med_min(min_medium_cnt),
    .strong_min(min_strong_cnt), .blk_valid(blk_valid), .blk_type(type_e),
    .blk_skip(blk_skip));

  assign blk_type = type_e;

  AST_LAST_TO_VALID: assert property (@(posedge clk) disable iff (!rst_sync)
    tile_last |=> blk_valid) else $error("no result after last pixel"); // R6

endmodule

// File: tb/sim_tile_classifier.sv
`timescale 1ns/1ps
module sim_tile_classifier;
  localparam int VW = 24;
  localparam int CW = 7;
  localparam int TW = 8;
  localparam int TH = 8;

  typedef struct packed {
    logic [2:0]    kind;
    logic [7:0]    amp;
    logic [VW-1:0] tt;
    logic [VW-1:0] te;
    logic [CW-1:0] tmin;
    logic [CW-1:0] mmin;
    logic [CW-1:0] smin;
    logic [2:0]    expt;
  } vec_t;

  // kinds: 0 flat, 1 checker +/-4, 2 vertical step, 3 spike at (3,3), 4 stripes, 5 corner spike
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd0}, // R4 R5 flat
    '{3'd1, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd1}, // R1 texture
    '{3'd1, 8'd0,   24'd320, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd1}, // R2 V==thr_texture
    '{3'd1, 8'd0,   24'd321, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd0}, // R2 V<thr_texture
    '{3'd2, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd3}, // R1 step
    '{3'd2, 8'd0,   24'd100, 24'd720000, 7'd10, 7'd8,  7'd20, 3'd3}, // R2 V==thr_edge
    '{3'd2, 8'd0,   24'd100, 24'd720001, 7'd10, 7'd8,  7'd20, 3'd1}, // R2 V<thr_edge
    '{3'd2, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd12, 7'd20, 3'd3}, // R4 count==min
    '{3'd2, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd13, 7'd20, 3'd2}, // R4 count<min
    '{3'd3, 8'd200, 24'd100, 24'd100000, 7'd10, 7'd10, 7'd20, 3'd2}, // R4 edge/texture
    '{3'd3, 8'd4,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd0}, // R4 uniform/texture merged
    '{3'd3, 8'd4,   24'd100, 24'd100000, 7'd9,  7'd8,  7'd20, 3'd1}, // R4 tex==min
    '{3'd4, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd4}, // R4 strong
    '{3'd4, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd36, 3'd4}, // R4 strong==min
    '{3'd4, 8'd0,   24'd100, 24'd100000, 7'd10, 7'd8,  7'd37, 3'd3}, // R4 strong<min
    '{3'd5, 8'd200, 24'd100, 24'd100000, 7'd10, 7'd8,  7'd20, 3'd2}  // R3 corner
  };

  logic          clk, rst_n, pix_valid;
  logic [7:0]    pix_data;
  logic [VW-1:0] thr_texture, thr_edge;
  logic [CW-1:0] min_texture_cnt, min_medium_cnt, min_strong_cnt;
  logic          blk_valid, blk_skip;
  logic [2:0]    blk_type;

  int errors = 0, checks = 0, cyc = 0, last_cyc = 0;
  int cap_n = 0;
  int cap_type [64];
  int cap_skip [64];
  int cap_cyc  [64];
  bit done = 0;

  tile_classifier u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .thr_texture(thr_texture), .thr_edge(thr_edge), .min_texture_cnt(min_texture_cnt),
    .min_medium_cnt(min_medium_cnt), .min_strong_cnt(min_strong_cnt),
    .blk_valid(blk_valid), .blk_type(blk_type), .blk_skip(blk_skip));

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (blk_valid && cap_n < 64) begin
      cap_type[cap_n] = int'(blk_type);
      cap_skip[cap_n] = int'(blk_skip);
      cap_cyc[cap_n]  = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_of(input int kind, input int amp, input int r, input int c);
    case (kind)
      0: return 8'd50;
      1: return ((r + c) % 2 == 1) ? 8'd104 : 8'd100;
      2: return (c >= 4) ? 8'd200 : 8'd0;
      3: return (r == 3 && c == 3) ? 8'(amp) : 8'd0;
      4: return (c % 2 == 1) ? 8'd200 : 8'd0;
      default: return (r == 0 && c == 0) ? 8'(amp) : 8'd0;
    endcase
  endfunction

  task automatic send_tile(input int kind, input int amp, input bit gaps, input bit idle_after);
    for (int r = 0; r < TH; r++) begin
      for (int c = 0; c < TW; c++) begin
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = pix_of(kind, amp, r, c);
        @(posedge clk);
        if (gaps) begin
          @(negedge clk);
          pix_valid = 1'b0;
          pix_data  = 8'hFF;
          @(posedge clk);
        end
      end
    end
    if (idle_after) begin
      @(negedge clk);
      pix_valid = 1'b0;
      last_cyc  = cyc;
    end
  endtask

  task automatic set_thr(input vec_t v);
    thr_texture     = v.tt;
    thr_edge        = v.te;
    min_texture_cnt = v.tmin;
    min_medium_cnt  = v.mmin;
    min_strong_cnt  = v.smin;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset blk_valid", int'(blk_valid), 0);
    chk("R9 reset blk_type", int'(blk_type), 0);
    chk("R9 reset blk_skip", int'(blk_skip), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 1'b1;
    pix_valid = 1'b0;
    pix_data = '0;
    set_thr(VECS[0]);
    #1 rst_n = 1'b0;
    do_reset();

    // table walk: one tile per vector
    for (int i = 0; i < NV; i++) begin
      set_thr(VECS[i]);
      n0 = cap_n;
      send_tile(int'(VECS[i].kind), int'(VECS[i].amp), 1'b0, 1'b1);
      repeat (2) @(posedge clk);
      #1;
      chk($sformatf("R4 vec%0d pulse count", i), cap_n - n0, 1);
      if (cap_n > n0) begin
        chk($sformatf("R4 vec%0d type", i), cap_type[cap_n-1], int'(VECS[i].expt));
        chk($sformatf("R5 vec%0d skip", i), cap_skip[cap_n-1], (VECS[i].expt == 3'd0) ? 1 : 0);
        chk($sformatf("R6 vec%0d latency", i), cap_cyc[cap_n-1] - last_cyc, 1);
      end
      chk($sformatf("R6 vec%0d pulse ended", i), int'(blk_valid), 0);
      chk($sformatf("R6 vec%0d type held", i), int'(blk_type), int'(VECS[i].expt));
    end

    // R7: idle cycle after every pixel, step tile
    set_thr(VECS[4]);
    n0 = cap_n;
    send_tile(2, 0, 1'b1, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    chk("R7 gapped pulse count", cap_n - n0, 1);
    if (cap_n > n0) chk("R7 gapped type", cap_type[cap_n-1], 3);

    // R8: back-to-back tiles, textured then stripes
    set_thr(VECS[1]);
    n0 = cap_n;
    send_tile(1, 0, 1'b0, 1'b0);
    send_tile(4, 0, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    chk("R8 back-to-back pulse count", cap_n - n0, 2);
    if (cap_n >= n0 + 2) begin
      chk("R8 first tile type", cap_type[n0], 1);
      chk("R8 second tile type", cap_type[n0+1], 4);
    end

    // R9: reset in mid-tile, then a full spike tile
    set_thr(VECS[4]);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = pix_of(4, 0, k / TW, k % TW);
    end
    n0 = cap_n;
    do_reset();
    send_tile(3, 200, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    chk("R9 post-reset pulse count", cap_n - n0, 1);
    if (cap_n > n0) chk("R9 post-reset type", cap_type[cap_n-1], 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule